// File: doc/BRIEF.md
# Watch-Clock Periodic Interrupt Timer

The block raises a periodic interrupt from a slow watch clock. The watch clock arrives as a one-cycle enable on the system clock. A fixed power-of-two prescaler turns that enable into a slow tick. A 7-bit counter advances once per tick. When the counter matches a programmable period, it wraps to zero and the block emits a single-cycle interrupt pulse. With a prescaler of width `PRE_W`, the interrupt interval is 2^PRE_W × (period + 1) enabled watch-clock cycles.

Software reaches the block through one byte-wide register location on a simple synchronous bus, and that location means different things on read and on write. A read returns the live counter value, with the top bit reading as zero. A write loads the period from the low seven bits. Its top bit is a one-shot clear command. A clear zeroes the counter and the prescaler, and it also wipes the period register, so software must write the period again after a clear. Programming a zero period is a misuse. The block still behaves predictably in that case and interrupts on every tick.

Top module: `wtick_timer`

## Requirements
- R1: Reset sets the counter to 0, the prescaler to 0 and the interrupt low, and it loads the period with 7Fh. The first interrupt after reset therefore comes 2^PRE_W × 128 enabled watch-clock cycles later.
- R2: When `rd_en` is high and `addr` equals `REG_ADDR`, `rdata` returns the counter in bits 6:0 and 0 in bit 7, in the same cycle. In every other case `rdata` is 0.
- R3: The counter steps by one for every 2^PRE_W cycles in which both `wck_en` and `run_en` are high. Cycles with `wck_en` low do not count.
- R4: When a tick arrives while the counter equals the period, the counter returns to 0 and `irq` is high for exactly one cycle. Consecutive interrupts are 2^PRE_W × (period + 1) enabled cycles apart.
- R5: A write to `REG_ADDR` with bit 7 = 0 loads bits 6:0 into the period. The counter and the prescaler are left unchanged.
- R6: A write to `REG_ADDR` with bit 7 = 1 zeroes the counter, the prescaler and the period in that write's clock edge. The clear acts once and is not stored.
- R7: With a period of 0, an interrupt is raised on every tick, that is every 2^PRE_W enabled cycles.
- R8: While `run_en` is low, the prescaler and the counter hold their values and no interrupt is raised. Register writes still take effect.
- R9: Reads have no effect on the counter, the prescaler or the period. Writes to any address other than `REG_ADDR` are ignored.
- R10: If the period is lowered below the current counter value, the counter keeps counting up through 127, wraps to 0 without an interrupt, and interrupts at the next match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wck_en | input | 1 | One-cycle enable marking each watch-clock cycle |
| run_en | input | 1 | Timer run enable; low freezes prescaler and counter |
| addr | input | ADDR_W | Bus address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | CNT_W+1 | Write data: bit 7 clear command, bits 6:0 period |
| rdata | output | CNT_W+1 | Read data: live counter, bit 7 zero |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench targets four corner cases:
- **Clear command.** The bench checks that a clear leaves the period at zero until software rewrites it. A design that only cleared the counter would keep the old interval instead of interrupting on every tick.
- **Timing after a clear.** The bench checks that the prescaler restarts on a clear. If it did not, the first interval after a clear would come out short by a fraction of a tick.
- **Lowering the period below the counter.** The bench lowers the period below the running counter and measures the delay to the next interrupt. A comparison using greater-or-equal would fire at once, while the correct design rolls through 127 first.
- **Freezing and decoding.** The bench also runs a frozen interval, a half-rate watch enable and a write to a foreign address. These expose a prescaler that ignores its enables and an address decode that is too loose.

// File: rtl/wtick_pkg.sv
// Package: constants shared by the watch-clock timer and its bench.
// Assumes the command bit sits directly above the period field.
package wtick_pkg;
    localparam int DEF_PRE_W    = 14;   // prescaler stages (2^14 divide)
    localparam int DEF_CNT_W    = 7;    // counter and period width
    localparam int DEF_ADDR_W   = 8;    // bus address width
    localparam logic [7:0] DEF_REG_ADDR = 8'h2C;
endpackage

// File: rtl/wtick_prescale.sv
// Module: free-running binary prescaler. Emits a one-cycle tick on the
// enabled cycle that completes 2^PRE_W enabled cycles. Assumes PRE_W >= 1.
module wtick_prescale #(
    parameter int PRE_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic restart,
    output logic tick
);
    logic [PRE_W-1:0] pre_q;

    // Count enabled cycles; a restart returns to the start of an interval.
    always_ff @(posedge clk) begin
        if (!rst_n)        pre_q <= '0;
        else if (restart)  pre_q <= '0;
        else if (step)     pre_q <= pre_q + 1'b1;
    end

    // Tick on the last enabled cycle of each interval.
    assign tick = step && !restart && (pre_q == {PRE_W{1'b1}});

    // R3: ticks are never back to back, since each one needs 2^PRE_W steps.
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wtick_regif.sv
// Module: shared-address register interface. A read returns the counter, and
// a write loads the period or issues a one-shot clear that also wipes the
// period. Assumes a single register location at REG_ADDR.
module wtick_regif #(
    parameter int              CNT_W      = 7,
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h2C,
    parameter logic [CNT_W-1:0]  PERIOD_RST = {CNT_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CNT_W:0]    wdata,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  period,
    output logic              clr_pulse,
    output logic [CNT_W:0]    rdata
);
    logic hit;
    logic wr_hit;

    assign hit       = (addr == REG_ADDR);
    assign wr_hit    = wr_en && hit;
    // The clear command lives only in the cycle of the write (self-clearing).
    assign clr_pulse = wr_hit && wdata[CNT_W];

    // Period register: load on write; a clear command wipes it.
    always_ff @(posedge clk) begin
        if (!rst_n)          period <= PERIOD_RST;
        else if (clr_pulse)  period <= '0;
        else if (wr_hit)     period <= wdata[CNT_W-1:0];
    end

    // Read mux: live counter with top bit zero, otherwise zero.
    assign rdata = (rd_en && hit) ? {1'b0, cnt} : '0;

    p_clr_wipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> (period == '0));
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !wdata[CNT_W]) |=> (period == $past(wdata[CNT_W-1:0])));
    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(period));
endmodule

// File: rtl/wtick_count.sv
// Module: period counter. Advances on each prescaler tick, wraps to zero on a
// match with the period and pulses the interrupt for one cycle. A clear
// takes priority over a tick.
module wtick_count #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    logic match;
    assign match = (cnt == period);

    // Counter and interrupt register: step, wrap on match, or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (clear) begin
                cnt <= '0;
            end else if (tick) begin
                if (match) begin
                    cnt <= '0;
                    irq <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_irq_wrapped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == '0));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt));
    p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && !match) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/wtick_timer.sv
// Module: watch-clock periodic interrupt timer (top). Combines the prescaler,
// the shared-address register interface and the period counter.
// Assumes wck_en is a one-cycle enable synchronous to clk.
module wtick_timer
    import wtick_pkg::*;
#(
    parameter int                PRE_W    = DEF_PRE_W,
    parameter int                CNT_W    = DEF_CNT_W,
    parameter int                ADDR_W   = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(DEF_REG_ADDR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wck_en,
    input  logic              run_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CNT_W:0]    wdata,
    output logic [CNT_W:0]    rdata,
    output logic              irq
);
    localparam logic [CNT_W-1:0] PERIOD_RST = {CNT_W{1'b1}};

    logic             step;
    logic             tick;
    logic             clr_pulse;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt;

    assign step = wck_en && run_en;

    wtick_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .restart (clr_pulse),
        .tick    (tick)
    );

    wtick_regif #(
        .CNT_W      (CNT_W),
        .ADDR_W     (ADDR_W),
        .REG_ADDR   (REG_ADDR),
        .PERIOD_RST (PERIOD_RST)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wdata     (wdata),
        .cnt       (cnt),
        .period    (period),
        .clr_pulse (clr_pulse),
        .rdata     (rdata)
    );

    wtick_count #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clear  (clr_pulse),
        .period (period),
        .cnt    (cnt),
        .irq    (irq)
    );

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> (cnt == '0) && !irq);
    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !clr_pulse) |=> $stable(cnt) && !irq);
    p_read_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !tick) |=> $stable(cnt) && $stable(period));
endmodule

// File: tb/wtick_timer_bench.sv
module wtick_timer_bench;
    localparam int PRE_W = 3;
    localparam int CNT_W = 7;
    localparam int ADDR_W = 8;
    localparam logic [7:0] RA = 8'h2C;
    localparam int TK = 1 << PRE_W;
    localparam int NV = 6;
    localparam logic [6:0] VP [NV] = '{7'd1, 7'd2, 7'd4, 7'd9, 7'd20, 7'd127};
    localparam int         VE [NV] = '{16, 24, 40, 80, 168, 1024};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wck_en = 1'b1;
    logic half_rate = 1'b0;
    logic run_en = 1'b1;
    logic [ADDR_W-1:0] addr = RA;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [CNT_W:0] wdata = '0;
    logic [CNT_W:0] rdata;
    logic irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(negedge clk) wck_en <= half_rate ? ~wck_en : 1'b1;

    wtick_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .REG_ADDR(RA))
    u_wtick_timer (.clk(clk), .rst_n(rst_n), .wck_en(wck_en), .run_en(run_en),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .irq(irq));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; addr = RA;
    endtask

    task automatic read_at(input logic [7:0] a, output int v);
        addr = a; rd_en = 1'b1; #1;
        v = int'(rdata);
        rd_en = 1'b0; addr = RA;
    endtask

    task automatic edges(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    // Count edges until irq is seen high at a falling edge.
    task automatic wait_irq(input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(posedge clk); n++; @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic clear_load(input logic [6:0] p);
        bus_write(RA, 8'h80);
        bus_write(RA, {1'b0, p});
    endtask

    initial begin
        int n, m, v;
        @(negedge clk); @(negedge clk); @(negedge clk);
        read_at(RA, v);
        chk(v == 0, "R1 counter after reset", v, 0);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        rst_n = 1'b1;
        wait_irq(3000, n);
        chk(n == TK * 128, "R1 first interval from period 7Fh", n, TK * 128);

        // Vector table: clear, load period, measure first and next interval.
        for (int i = 0; i < NV; i++) begin
            clear_load(VP[i]);
            wait_irq(3000, n);
            chk(n + 1 == VE[i], "R4 first interval after clear", n + 1, VE[i]);
            read_at(RA, v);
            chk(v == 0, "R4 counter wrapped on irq", v, 0);
            edges(1);
            chk(irq == 1'b0, "R4 irq lasts one cycle", irq, 0);
            if (i % 2 == 1) begin addr = RA; rd_en = 1'b1; end
            wait_irq(3000, m);
            rd_en = 1'b0;
            chk(m + 1 == VE[i], "R4 R9 steady interval", m + 1, VE[i]);
        end

        // R3 counter value and R2 read format.
        clear_load(7'd20);
        edges(39);
        read_at(RA, v);
        chk(v == 5, "R3 R2 counter after 40 cycles", v, 5);
        // R5: period load leaves the counter alone.
        bus_write(RA, 8'd10);
        read_at(RA, v);
        chk(v == 5, "R5 counter kept across period write", v, 5);
        wait_irq(3000, n);
        chk(n == 47, "R5 interrupt at new period", n, 47);

        // R9: foreign address write and read.
        clear_load(7'd20);
        edges(23);
        bus_write(RA ^ 8'h01, 8'h80);
        read_at(RA, v);
        chk(v == 3, "R9 foreign clear ignored", v, 3);
        read_at(RA ^ 8'h01, v);
        chk(v == 0, "R2 foreign read returns zero", v, 0);
        wait_irq(3000, n);
        chk(n == 143, "R9 period and prescaler untouched", n, 143);

        // R8: freeze with run_en low, write during freeze.
        clear_load(7'd4);
        edges(15);
        run_en = 1'b0;
        m = 0;
        for (int k = 0; k < 50; k++) begin edges(1); if (irq) m++; end
        bus_write(RA, 8'd6);
        if (irq) m++;
        read_at(RA, v);
        chk(v == 2, "R8 counter frozen", v, 2);
        chk(m == 0, "R8 no irq while frozen", m, 0);
        run_en = 1'b1;
        wait_irq(3000, n);
        chk(n == 5 * TK, "R8 resume with period written while frozen", n, 5 * TK);

        // R6 and R7: clear alone leaves period 0 (misuse case).
        bus_write(RA, 8'h80);
        read_at(RA, v);
        chk(v == 0, "R6 counter cleared", v, 0);
        $display("note: period zero misuse case under test");
        wait_irq(3000, n);
        chk(n == TK, "R6 R7 period wiped, irq every tick", n, TK);
        edges(1);
        wait_irq(3000, m);
        chk(m + 1 == TK, "R7 repeated irq every tick", m + 1, TK);

        // R10: lower the period below the counter.
        clear_load(7'd30);
        edges(79);
        read_at(RA, v);
        chk(v == 10, "R10 counter before lowering", v, 10);
        bus_write(RA, 8'd5);
        wait_irq(3000, n);
        chk(n == 991, "R10 wrap through max before match", n, 991);

        // R3: half-rate watch enable doubles the interval.
        clear_load(7'd3);
        half_rate = 1'b1;
        wait_irq(3000, n);
        edges(1);
        wait_irq(3000, m);
        chk(m + 1 == 2 * TK * 4, "R3 half-rate enable interval", m + 1, 2 * TK * 4);
        half_rate = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule